// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Divide-by-Zero Trap

This block divides one 32-bit operand by another over several clock cycles. Each operand pair carries a select bit. With the bit set, both operands are two's complement numbers and the quotient is truncated toward zero. With the bit clear, both operands are plain magnitudes. Inside, a restoring radix-2 engine produces one quotient bit per cycle, working on operand magnitudes. A final stage applies the sign of the result. No remainder is returned.

A zero divisor is detected when the operands are accepted, before any iteration. In that case the quotient is 0 and is ready one cycle later. A sticky status bit is set in every zero-divisor case. A trap request with a cause code is raised only when two enables are both high: the global exception enable and the divide-by-zero trap enable.

Operands enter on a valid/ready pair, and the quotient leaves on another valid/ready pair. The input side takes one pair at a time. `in_ready` is high only while the block is idle, so an operand pair offered during a division, or while a result waits, is not taken. The output side holds `res_valid` and `res_quotient` steady until the consumer raises `res_ready`. The block returns to idle on the cycle after that handshake.

Top module: `int_divider_trap`

## Requirements
- R1: With `in_signed` low, `res_quotient` equals the unsigned integer quotient of the 32-bit operands.
- R2: With `in_signed` high, the operands are two's complement and `res_quotient` is the quotient truncated toward zero, for every sign combination.
- R3: A zero divisor gives `res_quotient` = 0. `res_valid` is high right after the clock edge that accepts the operands.
- R4: A zero divisor sets `dz_status` whatever the enables are. The bit stays set until `dz_clear` is high at a clock edge. If a new zero divisor is accepted on that same edge, the set takes priority.
- R5: `trap_req` is high for exactly one cycle, right after the accepting edge, when the divisor is zero and `exc_enable` and `dz_trap_enable` were both 1 at acceptance. Otherwise it stays low.
- R6: `trap_cause` is 3'd5 while `trap_req` is high and 3'd0 at all other times.
- R7: Signed 0x80000000 divided by 0xFFFFFFFF returns 0x80000000. It sets neither `dz_status` nor `trap_req`.
- R8: For a nonzero divisor, `res_valid` first becomes high after the accepting edge plus 32 more rising edges.
- R9: `in_ready` is low from the accepting edge until the result handshake. An operand pair offered in that time is not taken and does not change the pending result.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_quotient` holds its value. After the handshake edge, `res_valid` is low.
- R11: After reset, `in_ready` is 1 and `res_valid`, `dz_status`, `trap_req` and `trap_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 32 | Divisor |
| res_valid | output | 1 | Quotient available |
| res_ready | input | 1 | Consumer takes the quotient |
| res_quotient | output | 32 | Quotient |
| exc_enable | input | 1 | Global exception enable |
| dz_trap_enable | input | 1 | Divide-by-zero trap configuration enable |
| dz_clear | input | 1 | Clears the sticky divide-by-zero bit |
| dz_status | output | 1 | Sticky divide-by-zero status bit |
| trap_req | output | 1 | Exception request pulse |
| trap_cause | output | 3 | Exception cause: 5 for divide by zero, 0 for none |

## Verification
Random operand pairs cover both signedness modes. Small divisors mixed with wide dividends exercise every iteration of the engine. Pairs in all four sign quadrants separate truncation toward zero from floor rounding and catch a missing sign fix. Directed cases run zero divisors under all four combinations of the two enables, which shows that the sticky bit and the trap are gated separately. Other directed cases cover the most-negative-by-minus-one pair, a set and a clear landing on the same edge, operands offered while the block is busy, and results held under back-pressure. Together these show that the input handshake and the hold behaviour are correct.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_DIVZ = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         quot_neg,
  output logic         dvs_zero
);
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    dvd_neg  = is_signed & dividend[W-1];
    dvs_neg  = is_signed & divisor[W-1];
    dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
    dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
    quot_neg = dvd_neg ^ dvs_neg;
    dvs_zero = (divisor == '0);
  end
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo,
  output logic         last
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    last  = run && (cnt_q == CW'(W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_mag;
      dvs_q <= dvs_mag;
      cnt_q <= '0;
    end else if (run) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quo = quo_q;

  // The partial remainder must stay below the divisor after every step
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(load)) |-> (rem_q < dvs_q)) // R1
    else $error("remainder not below divisor");
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int unsigned W = 32
) (
  input  logic         neg,
  input  logic         force_zero,
  input  logic [W-1:0] mag,
  output logic [W-1:0] result
);
  always_comb begin
    if (force_zero)
      result = '0;
    else if (neg)
      result = ~mag + 1'b1;
    else
      result = mag;
  end
endmodule

// File: rtl/div_zero_trap.sv
module div_zero_trap
  import div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_hit,
  input  logic               exc_en,
  input  logic               trap_en,
  input  logic               clr,
  output logic               status,
  output logic               trap,
  output logic [CAUSE_W-1:0] cause
);
  cause_e cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      trap    <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      if (zero_hit)
        status <= 1'b1;
      else if (clr)
        status <= 1'b0;
      trap    <= zero_hit & exc_en & trap_en;
      cause_q <= (zero_hit & exc_en & trap_en) ? CAUSE_DIVZ : CAUSE_NONE;
    end
  end

  assign cause = cause_q;

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> status) // R4
    else $error("sticky bit not set");

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status) // R4
    else $error("sticky bit lost");

  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && !(exc_en && trap_en)) |=> !trap) // R5
    else $error("trap without both enables");

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap) // R5
    else $error("trap longer than one cycle");

  AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (trap == (cause == CAUSE_DIVZ)) && (trap || cause == CAUSE_NONE)) // R6
    else $error("cause does not match trap");
endmodule

// File: rtl/int_divider_trap.sv
module int_divider_trap
  import div_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_signed,
  input  logic [W-1:0]       in_dividend,
  input  logic [W-1:0]       in_divisor,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [W-1:0]       res_quotient,
  input  logic               exc_enable,
  input  logic               dz_trap_enable,
  input  logic               dz_clear,
  output logic               dz_status,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause
);
  div_state_e   state_q;
  logic         accept;
  logic [W-1:0] dvd_mag;
  logic [W-1:0] dvs_mag;
  logic         quot_neg;
  logic         dvs_zero;
  logic         neg_q;
  logic         zero_q;
  logic         core_run;
  logic         core_last;
  logic [W-1:0] core_quo;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign core_run  = (state_q == ST_RUN);
  assign res_valid = (state_q == ST_DONE);

  div_operand_prep #(.W(W)) u_prep (
    .is_signed (in_signed),
    .dividend  (in_dividend),
    .divisor   (in_divisor),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .quot_neg  (quot_neg),
    .dvs_zero  (dvs_zero)
  );

  div_restoring_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && !dvs_zero),
    .run     (core_run),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .quo     (core_quo),
    .last    (core_last)
  );

  div_sign_fix #(.W(W)) u_fix (
    .neg        (neg_q),
    .force_zero (zero_q),
    .mag        (core_quo),
    .result     (res_quotient)
  );

  div_zero_trap u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero_hit(accept && dvs_zero),
    .exc_en  (exc_enable),
    .trap_en (dz_trap_enable),
    .clr     (dz_clear),
    .status  (dz_status),
    .trap    (trap_req),
    .cause   (trap_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          neg_q   <= quot_neg;
          zero_q  <= dvs_zero;
          state_q <= dvs_zero ? ST_DONE : ST_RUN;
        end
        ST_RUN:  if (core_last) state_q <= ST_DONE;
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_divisor == '0) |=> (res_valid && res_quotient == '0)) // R3
    else $error("zero divisor result wrong");

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready) // R9
    else $error("ready while busy");

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_quotient))) // R10
    else $error("result dropped under back-pressure");

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid) // R10
    else $error("result not released");
endmodule

// File: tb/int_divider_trap_bench.sv
module int_divider_trap_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_dividend = '0;
  logic [31:0] in_divisor = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_quotient;
  logic        exc_enable = 1'b0;
  logic        dz_trap_enable = 1'b0;
  logic        dz_clear = 1'b0;
  logic        dz_status;
  logic        trap_req;
  logic [2:0]  trap_cause;

  int checks = 0;
  int errors = 0;
  bit sticky = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider_trap u_int_divider_trap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_dividend(in_dividend), .in_divisor(in_divisor),
    .res_valid(res_valid), .res_ready(res_ready), .res_quotient(res_quotient),
    .exc_enable(exc_enable), .dz_trap_enable(dz_trap_enable), .dz_clear(dz_clear),
    .dz_status(dz_status), .trap_req(trap_req), .trap_cause(trap_cause)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_q(input logic [31:0] a, input logic [31:0] b, input bit sg);
    if (b == 0) return 32'd0;
    if (!sg) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    return $signed(a) / $signed(b);
  endfunction

  // One division; busy_poke offers a stray operand pair while busy
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit sg,
                         input bit ee, input bit te, input int hold, input bit busy_poke);
    logic [31:0] e;
    logic [31:0] first;
    bit zero;
    int lat;
    e = exp_q(a, b, sg);
    zero = (b == 0);
    @(negedge clk);
    chk(in_ready, "R9 idle ready", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_signed = sg; in_dividend = a; in_divisor = b;
    exc_enable = ee; dz_trap_enable = te;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    if (zero) sticky = 1'b1;
    chk(trap_req == (zero && ee && te), "R5 trap", {31'd0, trap_req}, {31'd0, zero && ee && te});
    chk(trap_cause == ((zero && ee && te) ? 3'd5 : 3'd0), "R6 cause", {29'd0, trap_cause},
        (zero && ee && te) ? 32'd5 : 32'd0);
    chk(dz_status == sticky, "R4 sticky", {31'd0, dz_status}, {31'd0, sticky});
    while (!res_valid && lat < 60) begin
      if (busy_poke && lat == 3) begin
        in_valid = 1'b1; in_dividend = ~a; in_divisor = 32'd0; in_signed = ~sg;
      end
      if (busy_poke && lat == 5) in_valid = 1'b0;
      if (busy_poke && lat == 4)
        chk(!in_ready, "R9 busy not ready", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(lat == (zero ? 1 : 33), zero ? "R3 latency" : "R8 latency", lat, zero ? 1 : 33);
    chk(res_quotient == e, zero ? "R3 zero quotient" : (sg ? "R2 signed" : "R1 unsigned"),
        res_quotient, e);
    first = res_quotient;
    for (int h = 0; h < hold; h++) begin
      if (busy_poke && h == 0) in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(res_valid && res_quotient == first, "R10 hold", res_quotient, first);
      chk(!in_ready, "R9 pending not ready", {31'd0, in_ready}, 32'd0);
      chk(!trap_req, "R5 single pulse", {31'd0, trap_req}, 32'd0);
    end
    chk(dz_status == sticky, "R4 sticky", {31'd0, dz_status}, {31'd0, sticky});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R10 release", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(in_ready && !res_valid && !dz_status && !trap_req && trap_cause == 0,
        "R11 reset", {27'd0, in_ready, res_valid, dz_status, trap_req, |trap_cause}, 32'h10);
    rst_n = 1'b1;
    // directed
    run_div(32'd100, 32'd7, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    run_div(32'hFFFF_FFFF, 32'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_div(-32'sd7, 32'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_div(32'd7, -32'sd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_div(-32'sd7, -32'sd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1, 1'b0); // R7
    chk(!dz_status, "R7 no flag", {31'd0, dz_status}, 32'd0);
    run_div(32'd5, 32'd9, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_div(32'h1234_5678, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 3, 1'b1);
    // zero divisor under all enable combinations, clear in between
    for (int k = 0; k < 4; k++) begin
      run_div(32'h55 + k, 32'd0, k[0], k[0], k[1], 2, 1'b0);
      @(negedge clk); dz_clear = 1'b1;
      @(negedge clk); dz_clear = 1'b0; sticky = 1'b0;
      chk(!dz_status, "R4 clear", {31'd0, dz_status}, 32'd0);
    end
    // clear and set on the same edge: set wins
    @(negedge clk);
    in_valid = 1'b1; in_divisor = 32'd0; in_dividend = 32'd9; dz_clear = 1'b1;
    exc_enable = 1'b0; dz_trap_enable = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; dz_clear = 1'b0; sticky = 1'b1;
    chk(dz_status, "R4 set wins over clear", {31'd0, dz_status}, 32'd1);
    chk(res_valid && res_quotient == 0, "R3 zero quotient", res_quotient, 32'd0);
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    // random
    for (int n = 0; n < 160; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      int sel;
      a = $urandom;
      sel = $urandom_range(0, 9);
      b = (sel < 3) ? 32'($urandom_range(1, 20)) : (sel == 3 ? 32'd0 :
          (sel == 4 ? -32'($urandom_range(1, 20)) : $urandom));
      run_div(a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 2), (n % 7) == 0);
    end
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule